// File: doc/BRIEF.md
# Dual Comparator Fault Monitor

This block watches two digital comparator results, one per monitored rail, and turns them into a fault indication for the board. For each channel, a configuration bit chooses which side of the threshold counts as bad. With the bit set, a high reading is a fault (overvoltage watch). With the bit clear, a low reading is a fault (undervoltage watch). Each comparator bit is first resynchronised to the block clock. A fault is only accepted once it has been seen for several consecutive clocks, so short glitches are rejected. The accepted per-channel fault state drives an active-low open-drain fault line, through a pull-down enable. The host can silence that line while the rails are being deliberately margined.

A four-bit status field serves host polling. Its low half shows the accepted fault state of each channel as it is now. Its high half holds a snapshot of that state, taken on one of two selectable events. The first event is the fault line becoming active. The second is an external agent pulling the shared READY wire low. Because several devices can share that wire, a board controller can freeze all of their comparator states at the same instant. Snapshot bits stay set until the host clears them by writing ones.

Top module: `cmpmon_top`

## Requirements
- R1: A channel's live status bit (status[0] for channel 0, status[1] for channel 1) reads 1 for fault and 0 for no fault. With `sense_high[i]`=1 a comparator level of 1 is a fault; with `sense_high[i]`=0 a level of 0 is a fault.
- R2: A raw fault is accepted only after two synchroniser stages and 4 consecutive faulty samples. The live bit therefore rises 6 clocks after the comparator level turns faulty and holds. It falls 3 clocks after the level turns healthy. A faulty level held for 3 clocks or fewer never sets the live bit.
- R3: `fault_pull` (1 = pull the fault line low) is high in every cycle in which any live bit is 1, unless suppression applies.
- R4: When `mask_in_margin`=1 and `margin_active`=1, `fault_pull` is 0 whatever the live bits are.
- R5: status[3:2] hold snapshot bits for channels 1 and 0. With `snap_sel`=0, the clock edge after a cycle in which `fault_pull` went from 0 to 1 ORs the live bits into the snapshot bits. The snapshot bits keep their value until the host clears them.
- R6: With `snap_sel`=1 and `ready_high_active`=1, a falling edge on `ready_pin` ORs the live bits into the snapshot bits. The pin passes through a two-stage synchroniser, so the capture appears 3 clocks after the pin goes low.
- R7: A low-going `ready_pin` captures nothing when `ready_high_active`=0, when `snap_sel`=0, or when `ready_drive`=1 (the block's own READY pull-down is active) at the moment the synchronised fall is seen.
- R8: A cycle with `clr_wr`=1 clears each snapshot bit whose `clr_data` bit is 1, leaving the others. If a capture happens in the same cycle, the capture wins for the channels it sets.
- R9: Synchronous reset `rst` sets all status bits to 0 and `fault_pull` to 0. It treats the READY pin as released (high), so no capture is triggered on leaving reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_level | input | 2 | Raw comparator results, asynchronous |
| sense_high | input | 2 | Per channel: 1 = high reading is a fault, 0 = low reading is a fault |
| margin_active | input | 1 | Rails are being margined |
| mask_in_margin | input | 1 | Suppress the fault line while margining |
| snap_sel | input | 1 | Snapshot event: 0 = fault line asserting, 1 = READY pin falling |
| ready_high_active | input | 1 | READY is configured active-high (arms the pin-low capture) |
| ready_drive | input | 1 | Block's own READY pull-down is active |
| ready_pin | input | 1 | Sensed level of the READY wire, asynchronous |
| clr_wr | input | 1 | Host write strobe for snapshot clearing |
| clr_data | input | 2 | Write-one-to-clear mask for snapshot bits |
| fault_pull | output | 1 | Enable for the open-drain pull-down of the active-low fault line |
| status | output | 4 | {snapshot[1:0], live[1:0]} |

## Verification
The checker continuously enforces several rules. The fault line obeys the margin suppression and is never active without a live fault. A snapshot bit rises only for a channel that was live, and, in fault-event mode, only right after the fault line rose. A snapshot bit falls only under a host clear naming it. The READY capture stays inert whenever it is disarmed or the block is driving the wire itself. The exact latencies cannot be judged from a single cycle: the 6-clock qualification, the 3-clock release, the rejection of a 3-clock glitch, the 3-clock READY capture delay and the clear-versus-capture collision. These are shown by the bench scenarios, which compare every cycle against a behavioural model.

// File: rtl/cmpmon_pkg.sv
package cmpmon_pkg;

    // Which event loads the snapshot half of the status field.
    typedef enum logic {
        EVT_FAULT = 1'b0,
        EVT_READY = 1'b1
    } snap_evt_e;

    // Both candidate capture events of one cycle.
    typedef struct packed {
        logic on_fault;
        logic on_ready;
    } evt_pair_t;

    // Turn a comparator level into a fault flag under the chosen sense.
    function automatic logic reading_faulty(input logic level, input logic high_is_bad);
        return high_is_bad ? level : ~level;
    endfunction

endpackage

// File: rtl/cmpmon_chan_filter.sv
module cmpmon_chan_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic high_is_bad,
    output logic qual
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(FILT_LEN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   flag_in;

    // Sense applied ahead of the synchroniser so reset value 0 means healthy.
    assign flag_in = cmpmon_pkg::reading_faulty(level, high_is_bad);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], flag_in};
            if (!sync_q[SYNC_STAGES-1])
                run_q <= '0;
            else if (run_q != RUN_MAX)
                run_q <= run_q + 1'b1;
        end
    end

    assign qual = (run_q == RUN_MAX);

endmodule

// File: rtl/cmpmon_ready_edge.sv
module cmpmon_ready_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic armed,
    input  logic self_drive,
    output logic fall_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // A low seen while this block pulls the wire itself is not an event.
    assign fall_evt = armed && prev_q && !sync_q[SYNC_STAGES-1] && !self_drive;

endmodule

// File: rtl/cmpmon_snapshot.sv
module cmpmon_snapshot #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] live,
    input  logic           capture,
    input  logic           clr_wr,
    input  logic [NCH-1:0] clr_mask,
    output logic [NCH-1:0] held
);
    logic [NCH-1:0] keep;
    logic [NCH-1:0] load;

    assign keep = held & ~(clr_wr ? clr_mask : '0);
    assign load = capture ? live : '0;

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= keep | load;
    end

endmodule

// File: rtl/cmpmon_top.sv
module cmpmon_top #(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   cmp_level,
    input  logic [NCH-1:0]   sense_high,
    input  logic             margin_active,
    input  logic             mask_in_margin,
    input  logic             snap_sel,
    input  logic             ready_high_active,
    input  logic             ready_drive,
    input  logic             ready_pin,
    input  logic             clr_wr,
    input  logic [NCH-1:0]   clr_data,
    output logic             fault_pull,
    output logic [2*NCH-1:0] status
);
    import cmpmon_pkg::*;

    logic [NCH-1:0] live;
    logic [NCH-1:0] held;
    logic           fault_q;
    logic           suppress;
    logic           rdy_fall;
    snap_evt_e      evt_kind;
    evt_pair_t      evts;
    logic           capture;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        cmpmon_chan_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk        (clk),
            .rst        (rst),
            .level      (cmp_level[g]),
            .high_is_bad(sense_high[g]),
            .qual       (live[g])
        );
    end

    assign suppress   = mask_in_margin && margin_active;
    assign fault_pull = (|live) && !suppress;

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= fault_pull;
    end

    assign evt_kind = snap_evt_e'(snap_sel);

    cmpmon_ready_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rdy (
        .clk       (clk),
        .rst       (rst),
        .pin       (ready_pin),
        .armed     (evt_kind == EVT_READY && ready_high_active),
        .self_drive(ready_drive),
        .fall_evt  (rdy_fall)
    );

    assign evts.on_fault = (evt_kind == EVT_FAULT) && fault_pull && !fault_q;
    assign evts.on_ready = rdy_fall;
    assign capture       = |evts;

    cmpmon_snapshot #(
        .NCH(NCH)
    ) u_snap (
        .clk     (clk),
        .rst     (rst),
        .live    (live),
        .capture (capture),
        .clr_wr  (clr_wr),
        .clr_mask(clr_data),
        .held    (held)
    );

    assign status = {held, live};

endmodule

// File: rtl/cmpmon_chk.sv
module cmpmon_chk #(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             margin_active,
    input logic             mask_in_margin,
    input logic             snap_sel,
    input logic             ready_high_active,
    input logic             ready_drive,
    input logic             clr_wr,
    input logic [NCH-1:0]   clr_data,
    input logic             fault_pull,
    input logic [2*NCH-1:0] status
);
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (status == '0 && !fault_pull));

    p_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (mask_in_margin && margin_active) |-> !fault_pull);

    p_pull_needs_live_r3: assert property (@(posedge clk) disable iff (rst)
        fault_pull |-> (|status[NCH-1:0]));

    p_live_drives_pull_r3: assert property (@(posedge clk) disable iff (rst)
        ((|status[NCH-1:0]) && !(mask_in_margin && margin_active)) |-> fault_pull);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        p_snap_from_live_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(status[NCH+i]) |-> $past(status[i]));

        p_snap_on_fault_edge_r5: assert property (@(posedge clk) disable iff (rst)
            ($past(snap_sel == 1'b0) && $rose(status[NCH+i]))
                |-> ($past(fault_pull) && !$past(fault_pull, 2)));

        p_clear_only_by_host_r8: assert property (@(posedge clk) disable iff (rst)
            $fell(status[NCH+i]) |-> $past(clr_wr && clr_data[i]));

        p_ready_disarmed_r7: assert property (@(posedge clk) disable iff (rst)
            $past(snap_sel == 1'b1 && (ready_drive || !ready_high_active))
                |-> !$rose(status[NCH+i]));
    end

endmodule

bind cmpmon_top cmpmon_chk #(
    .NCH(NCH)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .margin_active    (margin_active),
    .mask_in_margin   (mask_in_margin),
    .snap_sel         (snap_sel),
    .ready_high_active(ready_high_active),
    .ready_drive      (ready_drive),
    .clr_wr           (clr_wr),
    .clr_data         (clr_data),
    .fault_pull       (fault_pull),
    .status           (status)
);

// File: tb/sim_cmpmon_top.sv
module sim_cmpmon_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmp_level = 2'b10;
    logic [1:0] sense_high = 2'b01;
    logic       margin_active = 1'b0;
    logic       mask_in_margin = 1'b1;
    logic       snap_sel = 1'b0;
    logic       ready_high_active = 1'b1;
    logic       ready_drive = 1'b0;
    logic       ready_pin = 1'b1;
    logic       clr_wr = 1'b0;
    logic [1:0] clr_data = 2'b00;
    logic       fault_pull;
    logic [3:0] status;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string cur_req  = "R9";

    always #2 clk = ~clk;

    cmpmon_top u0 (
        .clk(clk), .rst(rst), .cmp_level(cmp_level), .sense_high(sense_high),
        .margin_active(margin_active), .mask_in_margin(mask_in_margin),
        .snap_sel(snap_sel), .ready_high_active(ready_high_active),
        .ready_drive(ready_drive), .ready_pin(ready_pin), .clr_wr(clr_wr),
        .clr_data(clr_data), .fault_pull(fault_pull), .status(status)
    );

    // ---------------- behavioural reference model ----------------
    bit [1:0] fhist[$];   // faulty flags per clock edge
    bit       rhist[$];   // READY pin level per clock edge
    int       run0 = 0, run1 = 0;
    bit [1:0] m_snap = 0;
    bit       m_pull_prev = 0;
    bit [1:0] m_live_old;
    bit       m_pull_now, m_ev, r_late, r_early;
    bit [1:0] f_now, f_dly;

    always @(posedge clk) begin
        if (rst) begin
            fhist.delete(); rhist.delete();
            run0 = 0; run1 = 0; m_snap = 0; m_pull_prev = 0;
        end else begin
            m_live_old = {run1 >= 4, run0 >= 4};
            m_pull_now = (m_live_old != 0) && !(mask_in_margin && margin_active);
            r_late  = (rhist.size() >= 2) ? rhist[rhist.size()-2] : 1'b1;
            r_early = (rhist.size() >= 3) ? rhist[rhist.size()-3] : 1'b1;
            if (snap_sel) m_ev = ready_high_active && r_early && !r_late && !ready_drive;
            else          m_ev = m_pull_now && !m_pull_prev;
            m_snap = (m_snap & ~(clr_wr ? clr_data : 2'b00)) | (m_ev ? m_live_old : 2'b00);
            f_dly = (fhist.size() >= 2) ? fhist[fhist.size()-2] : 2'b00;
            run0 = f_dly[0] ? ((run0 < 4) ? run0 + 1 : 4) : 0;
            run1 = f_dly[1] ? ((run1 < 4) ? run1 + 1 : 4) : 0;
            for (int c = 0; c < 2; c++)
                f_now[c] = sense_high[c] ? cmp_level[c] : ~cmp_level[c];
            fhist.push_back(f_now);
            rhist.push_back(ready_pin);
            if (fhist.size() > 4) void'(fhist.pop_front());
            if (rhist.size() > 4) void'(rhist.pop_front());
            m_pull_prev = m_pull_now;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // One clock: wait for the falling edge, then compare with the model.
    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            bit [1:0] e_live;
            bit       e_pull;
            @(negedge clk);
            e_live = {run1 >= 4, run0 >= 4};
            e_pull = (e_live != 0) && !(mask_in_margin && margin_active);
            check(status[1:0] == e_live, "live bits (R1 R2)", status[1:0], e_live);
            check(fault_pull == e_pull, "fault pull (R3 R4)", fault_pull, e_pull);
            check(status[3:2] == m_snap, "snapshot bits (R5 R6 R7 R8)", status[3:2], m_snap);
        end
    endtask

    task automatic clear_snap(input bit [1:0] m);
        clr_wr = 1'b1; clr_data = m; cyc(1);
        clr_wr = 1'b0; clr_data = 2'b00; cyc(1);
    endtask

    initial begin
        // R9: reset
        cur_req = "R9";
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check(status == 4'h0 && fault_pull == 1'b0, "R9 reset state", {fault_pull, status}, 0);
        cyc(8);
        cur_req = "R1";
        check(status == 4'h0, "R1 healthy levels give no fault", status, 0);

        // R1/R2: channel 0 overvoltage watch, level goes high
        cur_req = "R2";
        cmp_level = 2'b11;
        cyc(5);
        check(status[0] == 1'b0, "R2 not yet qualified at 5 clocks", status[0], 0);
        cyc(1);
        cur_req = "R1";
        check(status[0] == 1'b1, "R1 OV fault live at 6 clocks", status[0], 1);
        cur_req = "R3";
        check(fault_pull == 1'b1, "R3 pull active", fault_pull, 1);
        cur_req = "R5";
        cyc(1);
        check(status[3:2] == 2'b01, "R5 capture on pull rising", status[3:2], 1);

        // R8: clear while fault persists, no new event
        cur_req = "R8";
        clear_snap(2'b01);
        check(status[3:2] == 2'b00, "R8 clear by writing one", status[3:2], 0);

        // R2: release latency
        cur_req = "R2";
        cmp_level = 2'b10;
        cyc(2);
        check(status[0] == 1'b1, "R2 still live 2 clocks after release", status[0], 1);
        cyc(1);
        check(status[0] == 1'b0, "R2 dropped 3 clocks after release", status[0], 0);

        // R2: 3-clock glitch rejected
        cmp_level = 2'b11; cyc(3);
        cmp_level = 2'b10; cyc(8);
        check(status == 4'h0, "R2 short glitch ignored", status, 0);

        // R4/R3: undervoltage on channel 1 while margining
        cur_req = "R4";
        margin_active = 1'b1;
        cmp_level = 2'b00;
        cyc(8);
        check(status[1:0] == 2'b10, "R1 R4 UV fault live", status[1:0], 2);
        check(fault_pull == 1'b0, "R4 pull suppressed", fault_pull, 0);
        check(status[3:2] == 2'b00, "R4 no capture while suppressed", status[3:2], 0);
        cur_req = "R3";
        mask_in_margin = 1'b0;
        cyc(1);
        check(fault_pull == 1'b1, "R3 pull when unmasked", fault_pull, 1);
        check(status[3:2] == 2'b10, "R5 capture when unmasked", status[3:2], 2);
        margin_active = 1'b0; mask_in_margin = 1'b1;
        cyc(2);
        cur_req = "R5";
        check(status[3:2] == 2'b10, "R5 snapshot persists", status[3:2], 2);
        clear_snap(2'b11);

        // R6: READY-low capture
        cur_req = "R6";
        snap_sel = 1'b1;
        cyc(2);
        ready_pin = 1'b0;
        cyc(2);
        check(status[3:2] == 2'b00, "R6 not yet captured at 2 clocks", status[3:2], 0);
        cyc(1);
        check(status[3:2] == 2'b10, "R6 captured at 3 clocks", status[3:2], 2);
        ready_pin = 1'b1; cyc(4);
        clear_snap(2'b11);

        // R7: disarmed cases
        cur_req = "R7";
        ready_high_active = 1'b0;
        ready_pin = 1'b0; cyc(5);
        check(status[3:2] == 2'b00, "R7 ignored when active-low", status[3:2], 0);
        ready_pin = 1'b1; cyc(4);
        ready_high_active = 1'b1;
        ready_drive = 1'b1;
        ready_pin = 1'b0; cyc(5);
        check(status[3:2] == 2'b00, "R7 ignored when self-driven", status[3:2], 0);
        ready_drive = 1'b0; cyc(3);
        check(status[3:2] == 2'b00, "R7 no late capture after release", status[3:2], 0);
        ready_pin = 1'b1; cyc(4);
        snap_sel = 1'b0;
        ready_pin = 1'b0; cyc(5);
        check(status[3:2] == 2'b00, "R7 ignored in fault-event mode", status[3:2], 0);
        ready_pin = 1'b1; cyc(4);

        // R8: clear and capture in the same cycle
        cur_req = "R8";
        snap_sel = 1'b1;
        ready_pin = 1'b0; cyc(3);
        ready_pin = 1'b1; cyc(4);
        check(status[3:2] == 2'b10, "R6 second capture", status[3:2], 2);
        ready_pin = 1'b0; cyc(2);
        clr_wr = 1'b1; clr_data = 2'b10; cyc(1);
        clr_wr = 1'b0; clr_data = 2'b00;
        check(status[3:2] == 2'b10, "R8 capture beats clear", status[3:2], 2);
        ready_pin = 1'b1;
        cmp_level = 2'b10; cyc(6);
        cur_req = "R5";
        check(status == 4'b1000, "R5 snapshot outlives fault", status, 8);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL %s watchdog expired: actual running expected done", cur_req);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule